// File: doc/BRIEF.md
# Audio Transmit Sample Queue with Underrun Hold

This block buffers audio samples for one channel of a serial audio output. A processor-side write port pushes samples into a small first-in first-out store. A serial-side strobe asks for one sample per frame slot, and the block answers on a registered sample output. One instance serves one channel; a stereo link uses two.

The block raises a low-water service flag whenever the store is close to running dry. The flag can be routed to an interrupt line through a mask. If a slot asks for data while the store is empty, the block sets a sticky underrun status. It then keeps presenting the last sample it sent, so the listener hears a held level rather than noise. When fresh data is written, the next slot picks it up and normal playback resumes. The processor clears the underrun status with a one-cycle clear strobe.

Top module: `audio_tx_fifo`

## Requirements
- R1: A synchronous active-high reset leaves the store empty: `level` = 0, `full` = 0, `underrun` = 0, `sample_out` = 0 and `svc_req` = 1.
- R2: A write with `wr_en` = 1 while `full` = 0 stores `wr_data` and raises `level` by one after the clock edge. `full` is 1 exactly when `level` equals DEPTH (default 8). A write while `full` = 1 is ignored: it stores nothing and leaves `level` unchanged.
- R3: A `slot_req` while the store is non-empty removes the oldest sample. That sample appears on `sample_out` one clock after the request, and samples leave in the order they were written.
- R4: `svc_req` is 1 whenever `level` is LOW_MARK (default 4) or less, and 0 when `level` is LOW_MARK+1 or more. No software action is needed to clear it.
- R5: `irq` equals (`svc_req` AND `svc_mask`) OR `underrun`. With `svc_mask` = 0 the service flag still shows on `svc_req` but does not reach `irq`. A set `underrun` always drives `irq`.
- R6: A `slot_req` while `level` = 0 sets `underrun` after the clock edge. It stays set until it is cleared.
- R7: During an underrun, `sample_out` keeps the last sample removed from the store. If no sample has ever been removed since reset, it stays 0.
- R8: After an underrun, once a new sample has been written, the next `slot_req` delivers that new sample on `sample_out`.
- R9: A `urun_clr` pulse clears `underrun` after the clock edge. If an empty-store `slot_req` falls in the same cycle, the set wins and `underrun` stays 1.
- R10: A write and a `slot_req` in the same cycle on a non-empty, non-full store leave `level` unchanged. On an empty store, the write is stored, the slot still counts as an underrun, and `sample_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | SAMPLE_W | Sample to store |
| full | output | 1 | Store holds DEPTH samples |
| slot_req | input | 1 | Serial side asks for one sample |
| sample_out | output | SAMPLE_W | Sample presented to the serializer |
| level | output | clog2(DEPTH+1) | Number of samples held |
| svc_mask | input | 1 | Enables the service flag onto `irq` |
| svc_req | output | 1 | Low-water service flag |
| urun_clr | input | 1 | Clear strobe for the underrun status |
| underrun | output | 1 | Sticky underrun status |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can collide in a single cycle. The first is a processor write and a slot request arriving on an empty store. The bench forces this directly after draining, and expects the write to land while the slot still counts as an underrun with the output held. The second is the underrun clear strobe and a fresh empty-store request arriving together. The bench drives both in one cycle and expects the status to remain set. A behavioural queue model is compared with every output on every clock. It covers these directed collisions and a long random mix of writes, slots, mask changes and clears.

// File: rtl/atx_pkg.sv
package atx_pkg;

    localparam int SAMPLE_W_DEF = 16;
    localparam int DEPTH_DEF    = 8;
    localparam int LOW_MARK_DEF = 4;

    // one cycle's worth of store traffic
    typedef struct packed {
        logic push;
        logic pop;
    } fifo_op_t;

    // status carried out of the hold stage
    typedef struct packed {
        logic starved;   // slot asked while empty
        logic sticky;    // latched underrun
    } urun_state_t;

    function automatic logic below_mark(input int unsigned fill, input int unsigned mark);
        return fill <= mark;
    endfunction

endpackage

// File: rtl/atx_store.sv
module atx_store
    import atx_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEF,
    parameter int W     = SAMPLE_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  fifo_op_t                     op,
    input  logic [W-1:0]                 din,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam bit POW2 = (DEPTH == (1 << AW));

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp, wp_nx, rp_nx;
    logic [CW-1:0] cnt;

    generate
        if (POW2) begin : g_wrap_free
            assign wp_nx = wp + 1'b1;
            assign rp_nx = rp + 1'b1;
        end else begin : g_wrap_cmp
            assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (op.push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (op.push) wp <= wp_nx;
            if (op.pop)  rp <= rp_nx;
            case ({op.push, op.pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign count = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R2
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        op.pop |-> !empty); // R3

endmodule

// File: rtl/atx_hold.sv
module atx_hold
    import atx_pkg::*;
#(
    parameter int W = SAMPLE_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slot_req,
    input  logic          empty,
    input  logic [W-1:0]  head,
    input  logic          clr,
    output logic          pop,
    output logic [W-1:0]  sample,
    output urun_state_t   st
);
    logic [W-1:0] held;
    logic         sticky;
    logic         starved;

    assign starved = slot_req & empty;
    assign pop     = slot_req & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= '0;
            sticky <= 1'b0;
        end else begin
            if (pop) held <= head;
            if (starved)  sticky <= 1'b1;
            else if (clr) sticky <= 1'b0;
        end
    end

    assign sample     = held;
    assign st.starved = starved;
    assign st.sticky  = sticky;

    AST_URUN_SET: assert property (@(posedge clk) disable iff (rst)
        (slot_req && empty) |=> sticky); // R6
    AST_URUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sticky && !clr) |=> sticky); // R6
    AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        (slot_req && empty) |=> $stable(held)); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !(slot_req && empty)) |=> !sticky); // R9

endmodule

// File: rtl/atx_flags.sv
module atx_flags
    import atx_pkg::*;
#(
    parameter int DEPTH    = DEPTH_DEF,
    parameter int LOW_MARK = LOW_MARK_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    input  logic                        mask,
    input  logic                        urun,
    output logic                        svc,
    output logic                        irq
);
    assign svc = below_mark(int'(count), LOW_MARK);
    assign irq = (svc & mask) | urun;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!mask && !urun) |-> !irq); // R5
    AST_IRQ_URUN: assert property (@(posedge clk) disable iff (rst)
        urun |-> irq); // R5

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import atx_pkg::*;
#(
    parameter int SAMPLE_W = SAMPLE_W_DEF,
    parameter int DEPTH    = DEPTH_DEF,
    parameter int LOW_MARK = LOW_MARK_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SAMPLE_W-1:0]         wr_data,
    output logic                        full,
    input  logic                        slot_req,
    output logic [SAMPLE_W-1:0]         sample_out,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    input  logic                        svc_mask,
    output logic                        svc_req,
    input  logic                        urun_clr,
    output logic                        underrun,
    output logic                        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_op_t            op;
    logic                empty;
    logic                pop;
    logic [SAMPLE_W-1:0] head;
    logic [CW-1:0]       cnt;
    urun_state_t         ust;

    assign op.push = wr_en & ~full;
    assign op.pop  = pop;

    atx_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .din   (wr_data),
        .head  (head),
        .count (cnt),
        .full  (full),
        .empty (empty)
    );

    atx_hold #(.W(SAMPLE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .slot_req (slot_req),
        .empty    (empty),
        .head     (head),
        .clr      (urun_clr),
        .pop      (pop),
        .sample   (sample_out),
        .st       (ust)
    );

    atx_flags #(.DEPTH(DEPTH), .LOW_MARK(LOW_MARK)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .count (cnt),
        .mask  (svc_mask),
        .urun  (ust.sticky),
        .svc   (svc_req),
        .irq   (irq)
    );

    assign level    = cnt;
    assign underrun = ust.sticky;

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !slot_req) |=> (level == $past(level))); // R2
    AST_SVC_HIGH_FILL: assert property (@(posedge clk) disable iff (rst)
        (level > CW'(LOW_MARK)) |-> !svc_req); // R4
    AST_BALANCED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && slot_req && !full && level != '0) |=> (level == $past(level))); // R10

endmodule

// File: tb/test_audio_tx_fifo.sv
module test_audio_tx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int W     = 16;
    localparam int DEPTH = 8;
    localparam int LOW   = 4;
    localparam int WDOG  = 50000;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en, slot_req, svc_mask, urun_clr;
    logic [W-1:0] wr_data;
    logic         full, svc_req, underrun, irq;
    logic [W-1:0] sample_out;
    logic [3:0]   level;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int     q[$];
    int     m_held;
    bit     m_urun;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_tx_fifo #(.SAMPLE_W(W), .DEPTH(DEPTH), .LOW_MARK(LOW)) i_audio_tx_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .full(full),
        .slot_req(slot_req), .sample_out(sample_out), .level(level),
        .svc_mask(svc_mask), .svc_req(svc_req), .urun_clr(urun_clr),
        .underrun(underrun), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string ctx);
        int  n    = q.size();
        bit  slow = (n <= LOW);
        chk("R2", {ctx, " level"}, int'(level), n);
        chk("R2", {ctx, " full"}, int'(full), int'(n == DEPTH));
        chk("R3/R7", {ctx, " sample_out"}, int'(sample_out), m_held);
        chk("R4", {ctx, " svc_req"}, int'(svc_req), int'(slow));
        chk("R6/R9", {ctx, " underrun"}, int'(underrun), int'(m_urun));
        chk("R5", {ctx, " irq"}, int'(irq), int'((slow && svc_mask) || m_urun));
    endtask

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit w, input int wd, input bit s, input bit m, input bit c,
                       input string ctx);
        bit pre_empty, pre_full;
        wr_en = w; wr_data = W'(wd); slot_req = s; svc_mask = m; urun_clr = c;
        pre_empty = (q.size() == 0);
        pre_full  = (q.size() == DEPTH);
        @(posedge clk);
        if (s && !pre_empty) m_held = q.pop_front();
        if (w && !pre_full) q.push_back(wd & 16'hFFFF);
        if (s && pre_empty) m_urun = 1;
        else if (c)         m_urun = 0;
        @(negedge clk);
        compare_all(ctx);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; wr_data = '0; slot_req = 0; svc_mask = 0; urun_clr = 0;
        m_held = 0; m_urun = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        chk("R1", "level", int'(level), 0);
        chk("R1", "sample_out", int'(sample_out), 0);
        chk("R1", "underrun", int'(underrun), 0);
        chk("R1", "svc_req", int'(svc_req), 1);
        chk("R1", "full", int'(full), 0);

        // R7: underrun before any write gives zero; R6 sets status
        cyc(0, 0, 1, 1, 0, "R7 early underrun");
        chk("R7", "zero hold", int'(sample_out), 0);
        chk("R6", "set", int'(underrun), 1);
        cyc(0, 0, 0, 0, 0, "R6 sticky");
        chk("R5", "irq from underrun with mask off", int'(irq), 1);
        cyc(0, 0, 0, 0, 1, "R9 clear");
        chk("R9", "cleared", int'(underrun), 0);

        // R2/R4/R5: fill past full, mask both ways
        for (int i = 0; i < DEPTH + 2; i++) begin
            cyc(1, 16'h1100 + i, 0, i[0], 0, "R2 fill");
            if (q.size() == LOW)     chk("R4", "svc at mark", int'(svc_req), 1);
            if (q.size() == LOW + 1) chk("R4", "svc above mark", int'(svc_req), 0);
        end
        chk("R2", "full after overfill", int'(full), 1);
        chk("R2", "level capped", int'(level), DEPTH);

        // R10: balanced write+slot while partly full
        cyc(0, 0, 1, 1, 0, "R3 pop");
        chk("R3", "first out", int'(sample_out), 16'h1100);
        cyc(1, 16'h2222, 1, 1, 0, "R10 balanced");
        chk("R10", "level unchanged", int'(level), DEPTH - 1);

        // R3/R5: drain, mask off shows flag without irq
        while (q.size() > 0) cyc(0, 0, 1, 0, 0, "R3 drain");
        chk("R5", "flag without irq", int'(svc_req && !irq), 1);
        chk("R3", "last drained", int'(sample_out), 16'h2222);

        // R7: repeated underrun holds last sample
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, "R7 hold");
        chk("R7", "held value", int'(sample_out), 16'h2222);

        // R9: clear collides with a fresh starved slot
        cyc(0, 0, 1, 0, 1, "R9 set wins");
        chk("R9", "set wins", int'(underrun), 1);

        // R10: write and slot together on empty store
        cyc(1, 16'h3333, 1, 0, 0, "R10 empty collide");
        chk("R10", "write landed", int'(level), 1);
        chk("R10", "output held", int'(sample_out), 16'h2222);

        // R8: next slot resumes with new data
        cyc(0, 0, 1, 0, 1, "R8 resume");
        chk("R8", "new sample", int'(sample_out), 16'h3333);
        chk("R9", "cleared after resume", int'(underrun), 0);

        // random mix
        for (int i = 0; i < 2000; i++) begin
            cyc(($urandom_range(0, 99) < 55), int'($urandom_range(0, 65535)),
                ($urandom_range(0, 99) < 45), $urandom_range(0, 1) == 1,
                ($urandom_range(0, 99) < 10), "random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule